// File: doc/BRIEF.md
# Dual-Issue Slot Decoder and Lane Steering

This block sits between instruction fetch and two execution lanes. Each cycle it can accept one 32-bit fetch word, called an issue slot, together with the program counter of the thread that owns it and that thread's number. It decodes the slot into at most one instruction for the memory lane and at most one for the resource lane. For each lane it gives a valid bit, the instruction bits, the destination register and a write flag. It also returns the program counter the thread should fetch next.

Every thread has its own mode bit. In dual mode the slot holds either one 32-bit instruction or two 16-bit instructions that issue together. In this mode the program counter counts whole slots and must be word aligned. In single mode one instruction issues per cycle, and the program counter steps by two or four bytes.

The block raises an exception for any of these cases:
- a misaligned program counter;
- a pair whose two destination registers are the same;
- a pair where both instructions can only run on the same lane.

When an exception is raised, no lane is issued and the next program counter stays on the faulting slot, so the slot is executed again. All outputs are registered and appear one cycle after the slot is presented.

Top module: `dual_slot_steer`

## Requirements
- R1: Instruction size is taken from bits [15:14] of the lower halfword of the slot. The value 2'b11 means one 32-bit instruction spanning the whole word. Any other value means the lower halfword is a 16-bit instruction.
- R2: Bits [13:12] of an instruction's first halfword give its class: 00 basic arithmetic, 01 memory, 10 branch, 11 resource. Memory and branch instructions issue only on the memory lane. Resource instructions issue only on the resource lane. Bits [3:0] are the destination register. Branches write no destination (the write flag is 0).
- R3: In dual mode with a word-aligned PC and two 16-bit instructions, both issue in the same cycle and next_pc is PC+4. The lower halfword's instruction takes the lane its class requires. A basic arithmetic instruction takes whichever lane the other one leaves free. When both are arithmetic, the lower one goes to the memory lane.
- R4: In dual mode, a pair whose two instructions both require the memory lane, or both require the resource lane, raises cause 2'b10.
- R5: In dual mode, a pair in which both instructions write the same destination register raises cause 2'b01.
- R6: In dual mode, a PC with bit 1 or bit 0 set raises cause 2'b11.
- R7: In single mode, PC bit 1 selects which halfword issues. The instruction goes to its class lane, with arithmetic going to the memory lane. next_pc is PC+2 for a 16-bit instruction and PC+4 for a 32-bit one. No pair checks are made. PC bit 0 set, or a 32-bit instruction (bits [31:30]=2'b11) in the upper halfword, raises cause 2'b11.
- R8: On any exception both lane valids are 0, exc is 1 and next_pc equals the slot PC. When several causes apply, 2'b11 wins over 2'b01, and 2'b01 wins over 2'b10.
- R9: The mode used for a slot is bit slot_tid of thread_dual, where 1 means dual mode.
- R10: While reset is high, and in the first cycle after it, out_vld, both lane valids and exc are 0 and exc_cause is 2'b00.
- R11: Results appear on the clock edge after the slot is presented. A cycle with slot_valid low produces out_vld, lane valids and exc all 0.
- R12: In dual mode, a 32-bit instruction issues alone, on the lane its class requires (arithmetic goes to the memory lane), with all 32 bits on that lane's instruction output. next_pc is PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 1 | A slot is presented this cycle |
| slot_tid | input | TID_W | Thread owning the slot |
| slot_pc | input | PC_W | Byte address of the slot |
| slot_word | input | 32 | Fetched slot; the lower halfword comes first |
| thread_dual | input | NUM_THR | Per-thread mode bit, 1 = dual mode |
| out_vld | output | 1 | A slot was decoded in the previous cycle |
| mem_vld | output | 1 | Memory lane issues an instruction |
| mem_ins | output | 32 | Memory lane instruction (a 16-bit instruction is zero-extended) |
| mem_dst | output | REG_W | Memory lane destination register |
| mem_wr | output | 1 | Memory lane instruction writes its destination |
| res_vld | output | 1 | Resource lane issues an instruction |
| res_ins | output | 32 | Resource lane instruction |
| res_dst | output | REG_W | Resource lane destination register |
| res_wr | output | 1 | Resource lane instruction writes its destination |
| exc | output | 1 | Exception raised for the slot |
| exc_cause | output | 2 | 00 none, 01 destination clash, 10 lane conflict, 11 misaligned |
| next_pc | output | PC_W | PC for the thread's next fetch |

## Verification
The bench builds the block with four threads, a 4-bit destination field and a 32-bit PC. The mode vector is fixed so that threads 0 and 2 run in dual mode and threads 1 and 3 in single mode. This makes it possible to switch between pairing and single-instruction stepping from one slot to the next just by changing the thread number, and to confirm that mode is looked up per thread. With a 4-bit destination field, clashes can be built on chosen registers such as 7 and 9. Program counters can be placed on every halfword and byte offset to reach each alignment fault.

// File: rtl/ds_pkg.sv
package ds_pkg;

  typedef enum logic [1:0] {
    CLS_ARITH  = 2'b00,
    CLS_MEM    = 2'b01,
    CLS_BRANCH = 2'b10,
    CLS_RES    = 2'b11
  } ins_cls_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_CLASH = 2'b01,
    CAUSE_LANE  = 2'b10,
    CAUSE_ALIGN = 2'b11
  } exc_cause_e;

  localparam logic [1:0] WIDE_MARK = 2'b11;

  function automatic logic cls_needs_mem(input ins_cls_e c);
    return (c == CLS_MEM) || (c == CLS_BRANCH);
  endfunction

  function automatic logic cls_needs_res(input ins_cls_e c);
    return (c == CLS_RES);
  endfunction

endpackage

// File: rtl/ds_hw_classify.sv
module ds_hw_classify
  import ds_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [15:0]      hw,
  output logic             wide,
  output ins_cls_e         cls,
  output logic             writes,
  output logic [REG_W-1:0] dst
);

  localparam int DST_BITS = (REG_W < 12) ? REG_W : 12;

  always_comb begin
    wide   = (hw[15:14] == WIDE_MARK);
    cls    = ins_cls_e'(hw[13:12]);
    writes = (cls != CLS_BRANCH);
    dst    = '0;
    dst[DST_BITS-1:0] = hw[DST_BITS-1:0];
  end

endmodule

// File: rtl/ds_lane_steer.sv
module ds_lane_steer
  import ds_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  ins_cls_e         cls_a,
  input  logic             wr_a,
  input  logic [REG_W-1:0] dst_a,
  input  ins_cls_e         cls_b,
  input  logic             wr_b,
  input  logic [REG_W-1:0] dst_b,
  output logic             a_on_res,
  output logic             lane_conflict,
  output logic             dst_clash
);

  logic nm_a, nm_b, nr_a, nr_b;

  always_comb begin
    nm_a = cls_needs_mem(cls_a);
    nm_b = cls_needs_mem(cls_b);
    nr_a = cls_needs_res(cls_a);
    nr_b = cls_needs_res(cls_b);
    // lower instruction keeps its fixed lane; arithmetic yields to partner
    a_on_res      = nr_a | (!nm_a && nm_b);
    lane_conflict = (nm_a && nm_b) || (nr_a && nr_b);
    dst_clash     = wr_a && wr_b && (dst_a == dst_b);
  end

endmodule

// File: rtl/dual_slot_steer.sv
module dual_slot_steer
  import ds_pkg::*;
#(
  parameter int NUM_THR = 8,
  parameter int REG_W   = 4,
  parameter int PC_W    = 32,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_valid,
  input  logic [TID_W-1:0]   slot_tid,
  input  logic [PC_W-1:0]    slot_pc,
  input  logic [31:0]        slot_word,
  input  logic [NUM_THR-1:0] thread_dual,
  output logic               out_vld,
  output logic               mem_vld,
  output logic [31:0]        mem_ins,
  output logic [REG_W-1:0]   mem_dst,
  output logic               mem_wr,
  output logic               res_vld,
  output logic [31:0]        res_ins,
  output logic [REG_W-1:0]   res_dst,
  output logic               res_wr,
  output logic               exc,
  output logic [1:0]         exc_cause,
  output logic [PC_W-1:0]    next_pc
);

  localparam int NHW = 2;

  logic             hw_wide [NHW];
  ins_cls_e         hw_cls  [NHW];
  logic             hw_wr   [NHW];
  logic [REG_W-1:0] hw_dst  [NHW];

  for (genvar g = 0; g < NHW; g++) begin : g_hw
    ds_hw_classify #(.REG_W(REG_W)) i_cls (
      .hw     (slot_word[16*g +: 16]),
      .wide   (hw_wide[g]),
      .cls    (hw_cls[g]),
      .writes (hw_wr[g]),
      .dst    (hw_dst[g])
    );
  end

  logic a_on_res, lane_conflict, dst_clash;

  ds_lane_steer #(.REG_W(REG_W)) i_steer (
    .cls_a         (hw_cls[0]),
    .wr_a          (hw_wr[0]),
    .dst_a         (hw_dst[0]),
    .cls_b         (hw_cls[1]),
    .wr_b          (hw_wr[1]),
    .dst_b         (hw_dst[1]),
    .a_on_res      (a_on_res),
    .lane_conflict (lane_conflict),
    .dst_clash     (dst_clash)
  );

  // next-state values
  logic             dual;
  logic             sel;
  exc_cause_e       n_cause;
  logic             n_mvld, n_rvld, n_mwr, n_rwr;
  logic [31:0]      n_mins, n_rins;
  logic [REG_W-1:0] n_mdst, n_rdst;
  logic [PC_W-1:0]  n_npc;

  always_comb begin
    dual    = thread_dual[slot_tid];
    sel     = slot_pc[1];
    n_cause = CAUSE_NONE;
    n_mvld  = 1'b0;
    n_rvld  = 1'b0;
    n_mwr   = 1'b0;
    n_rwr   = 1'b0;
    n_mins  = '0;
    n_rins  = '0;
    n_mdst  = '0;
    n_rdst  = '0;
    n_npc   = slot_pc + PC_W'(4);

    if (dual) begin
      if (slot_pc[1:0] != 2'b00) begin
        n_cause = CAUSE_ALIGN;
      end else if (hw_wide[0]) begin
        if (cls_needs_res(hw_cls[0])) begin
          n_rvld = 1'b1; n_rins = slot_word; n_rdst = hw_dst[0]; n_rwr = hw_wr[0];
        end else begin
          n_mvld = 1'b1; n_mins = slot_word; n_mdst = hw_dst[0]; n_mwr = hw_wr[0];
        end
      end else if (dst_clash) begin
        n_cause = CAUSE_CLASH;
      end else if (lane_conflict) begin
        n_cause = CAUSE_LANE;
      end else begin
        n_mvld = 1'b1;
        n_rvld = 1'b1;
        if (a_on_res) begin
          n_rins = {16'h0, slot_word[15:0]};  n_rdst = hw_dst[0]; n_rwr = hw_wr[0];
          n_mins = {16'h0, slot_word[31:16]}; n_mdst = hw_dst[1]; n_mwr = hw_wr[1];
        end else begin
          n_mins = {16'h0, slot_word[15:0]};  n_mdst = hw_dst[0]; n_mwr = hw_wr[0];
          n_rins = {16'h0, slot_word[31:16]}; n_rdst = hw_dst[1]; n_rwr = hw_wr[1];
        end
      end
    end else begin
      if (slot_pc[0] || (sel && hw_wide[1])) begin
        n_cause = CAUSE_ALIGN;
      end else if (!sel && hw_wide[0]) begin
        n_npc = slot_pc + PC_W'(4);
        if (cls_needs_res(hw_cls[0])) begin
          n_rvld = 1'b1; n_rins = slot_word; n_rdst = hw_dst[0]; n_rwr = hw_wr[0];
        end else begin
          n_mvld = 1'b1; n_mins = slot_word; n_mdst = hw_dst[0]; n_mwr = hw_wr[0];
        end
      end else begin
        n_npc = slot_pc + PC_W'(2);
        if (cls_needs_res(hw_cls[sel])) begin
          n_rvld = 1'b1; n_rins = {16'h0, slot_word[16*sel +: 16]};
          n_rdst = hw_dst[sel]; n_rwr = hw_wr[sel];
        end else begin
          n_mvld = 1'b1; n_mins = {16'h0, slot_word[16*sel +: 16]};
          n_mdst = hw_dst[sel]; n_mwr = hw_wr[sel];
        end
      end
    end

    if (n_cause != CAUSE_NONE) n_npc = slot_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      mem_vld   <= 1'b0;
      res_vld   <= 1'b0;
      mem_wr    <= 1'b0;
      res_wr    <= 1'b0;
      mem_ins   <= '0;
      res_ins   <= '0;
      mem_dst   <= '0;
      res_dst   <= '0;
      exc       <= 1'b0;
      exc_cause <= CAUSE_NONE;
      next_pc   <= '0;
    end else begin
      out_vld   <= slot_valid;
      mem_vld   <= slot_valid && n_mvld;
      res_vld   <= slot_valid && n_rvld;
      mem_wr    <= slot_valid && n_mwr;
      res_wr    <= slot_valid && n_rwr;
      mem_ins   <= n_mins;
      res_ins   <= n_rins;
      mem_dst   <= n_mdst;
      res_dst   <= n_rdst;
      exc       <= slot_valid && (n_cause != CAUSE_NONE);
      exc_cause <= slot_valid ? n_cause : CAUSE_NONE;
      next_pc   <= n_npc;
    end
  end

  // R8: an exception aborts both lanes
  p_exc_no_issue_r8: assert property (@(posedge clk) disable iff (rst)
    exc |-> (!mem_vld && !res_vld));

  // R8: the faulting slot is re-executed
  p_exc_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    slot_valid && thread_dual[slot_tid] && (slot_pc[1:0] != 2'b00)
      |=> exc && (next_pc == $past(slot_pc)));

  // R5: two issued writers never share a destination
  p_dst_disjoint_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_vld && res_vld && mem_wr && res_wr) |-> (mem_dst != res_dst));

  // R11: an empty cycle produces nothing
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !slot_valid |=> (!out_vld && !mem_vld && !res_vld && !exc));

  // R3: a clean dual-mode slot advances by one whole slot
  p_slot_step_r3: assert property (@(posedge clk) disable iff (rst)
    slot_valid && thread_dual[slot_tid] |=> exc || (next_pc == $past(slot_pc) + PC_W'(4)));

endmodule

// File: tb/test_dual_slot_steer.sv
`timescale 1ns/1ps
module test_dual_slot_steer;

  localparam int NUM_THR = 4;
  localparam int REG_W   = 4;
  localparam int PC_W    = 32;
  localparam int TID_W   = 2;
  localparam int NVEC    = 21;

  logic               clk = 1'b0;
  logic               rst;
  logic               slot_valid;
  logic [TID_W-1:0]   slot_tid;
  logic [PC_W-1:0]    slot_pc;
  logic [31:0]        slot_word;
  logic [NUM_THR-1:0] thread_dual;
  logic               out_vld, mem_vld, mem_wr, res_vld, res_wr, exc;
  logic [31:0]        mem_ins, res_ins;
  logic [REG_W-1:0]   mem_dst, res_dst;
  logic [1:0]         exc_cause;
  logic [PC_W-1:0]    next_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dual_slot_steer #(.NUM_THR(NUM_THR), .REG_W(REG_W), .PC_W(PC_W)) i_dual_slot_steer (
    .clk, .rst, .slot_valid, .slot_tid, .slot_pc, .slot_word, .thread_dual,
    .out_vld, .mem_vld, .mem_ins, .mem_dst, .mem_wr,
    .res_vld, .res_ins, .res_dst, .res_wr, .exc, .exc_cause, .next_pc
  );

  // {tid, pc, word, exp mem_vld, exp res_vld, exp cause, exp next_pc}
  localparam logic [101:0] VEC [NVEC] = '{
    {2'd0, 32'h100, 32'h3002_1001, 1'b1, 1'b1, 2'b00, 32'h104}, // R3 mem lo, res hi
    {2'd0, 32'h200, 32'h1003_3004, 1'b1, 1'b1, 2'b00, 32'h204}, // R3 res lo, mem hi
    {2'd0, 32'h208, 32'h0005_0006, 1'b1, 1'b1, 2'b00, 32'h20C}, // R3 both arith
    {2'd0, 32'h20C, 32'h1001_1002, 1'b0, 1'b0, 2'b10, 32'h20C}, // R4 mem+mem
    {2'd0, 32'h210, 32'h3001_3002, 1'b0, 1'b0, 2'b10, 32'h210}, // R4 res+res
    {2'd0, 32'h214, 32'h1001_2000, 1'b0, 1'b0, 2'b10, 32'h214}, // R4 branch+mem
    {2'd0, 32'h218, 32'h0007_0007, 1'b0, 1'b0, 2'b01, 32'h218}, // R5 arith clash
    {2'd0, 32'h21C, 32'h3009_1009, 1'b0, 1'b0, 2'b01, 32'h21C}, // R5 mem/res clash
    {2'd0, 32'h220, 32'h0000_2000, 1'b1, 1'b1, 2'b00, 32'h224}, // R2 branch writes nothing
    {2'd0, 32'h300, 32'h0000_D001, 1'b1, 1'b0, 2'b00, 32'h304}, // R12 wide mem
    {2'd0, 32'h304, 32'h0000_F002, 1'b0, 1'b1, 2'b00, 32'h308}, // R12 wide resource
    {2'd0, 32'h302, 32'h3002_1001, 1'b0, 1'b0, 2'b11, 32'h302}, // R6 halfword pc
    {2'd1, 32'h400, 32'h3002_1001, 1'b1, 1'b0, 2'b00, 32'h402}, // R7 lower half
    {2'd1, 32'h402, 32'h3002_1001, 1'b0, 1'b1, 2'b00, 32'h404}, // R7 upper half
    {2'd1, 32'h400, 32'h1001_1002, 1'b1, 1'b0, 2'b00, 32'h402}, // R7 no pair check
    {2'd1, 32'h404, 32'h0000_F002, 1'b0, 1'b1, 2'b00, 32'h408}, // R7 wide step 4
    {2'd1, 32'h406, 32'hF002_0000, 1'b0, 1'b0, 2'b11, 32'h406}, // R7 wide in upper half
    {2'd3, 32'h401, 32'h0000_0001, 1'b0, 1'b0, 2'b11, 32'h401}, // R7 odd pc
    {2'd2, 32'h500, 32'h1001_1001, 1'b0, 1'b0, 2'b01, 32'h500}, // R8 clash beats conflict
    {2'd3, 32'h400, 32'h0007_0007, 1'b1, 1'b0, 2'b00, 32'h402}, // R9 thread 3 single
    {2'd0, 32'h101, 32'h0007_0007, 1'b0, 1'b0, 2'b11, 32'h101}  // R8 align beats clash
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [TID_W-1:0] t, input logic [31:0] pc, input logic [31:0] w);
    @(negedge clk);
    slot_valid = 1'b1;
    slot_tid   = t;
    slot_pc    = pc;
    slot_word  = w;
    @(negedge clk);
    slot_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst         = 1'b1;
    slot_valid  = 1'b0;
    slot_tid    = '0;
    slot_pc     = '0;
    slot_word   = '0;
    thread_dual = 4'b0101;
    repeat (3) @(negedge clk);
    check("R10 out_vld", 64'(out_vld), 64'd0);
    check("R10 lanes",   64'({mem_vld, res_vld, exc}), 64'd0);
    check("R10 cause",   64'(exc_cause), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after release", 64'({out_vld, mem_vld, res_vld, exc}), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][101:100], VEC[i][99:68], VEC[i][67:36]);
      check($sformatf("vec%0d out_vld R11", i), 64'(out_vld), 64'd1);
      check($sformatf("vec%0d mem_vld", i), 64'(mem_vld), 64'(VEC[i][35]));
      check($sformatf("vec%0d res_vld", i), 64'(res_vld), 64'(VEC[i][34]));
      check($sformatf("vec%0d cause R8", i), 64'(exc_cause), 64'(VEC[i][33:32]));
      check($sformatf("vec%0d exc R8", i), 64'(exc), 64'(VEC[i][33:32] != 2'b00));
      check($sformatf("vec%0d next_pc", i), 64'(next_pc), 64'(VEC[i][31:0]));
    end

    // R3 routing: lower mem to mem lane, upper resource to resource lane
    drive(2'd0, 32'h100, 32'h3002_1001);
    check("R3 mem_ins", 64'(mem_ins), 64'h1001);
    check("R3 mem_dst", 64'(mem_dst), 64'd1);
    check("R3 res_ins", 64'(res_ins), 64'h3002);
    check("R3 res_dst", 64'(res_dst), 64'd2);
    // R3 resource in lower half, arithmetic upper takes memory lane
    drive(2'd0, 32'h100, 32'h000A_3004);
    check("R3 res gets lower", 64'(res_ins), 64'h3004);
    check("R3 arith to mem", 64'(mem_ins), 64'h000A);
    // R2 branch writes no destination
    drive(2'd0, 32'h100, 32'h0003_2000);
    check("R2 branch on mem", 64'(mem_ins), 64'h2000);
    check("R2 branch wr", 64'(mem_wr), 64'd0);
    check("R2 arith wr", 64'(res_wr), 64'd1);
    // R1/R12 wide arithmetic keeps full word on memory lane
    drive(2'd2, 32'h600, 32'hABCD_C005);
    check("R12 wide ins", 64'(mem_ins), 64'hABCD_C005);
    check("R1 wide single issue", 64'({mem_vld, res_vld}), 64'b10);
    check("R12 wide dst", 64'(mem_dst), 64'd5);
    // R1 lower size 2'b10 is still 16-bit: pair issues
    drive(2'd0, 32'h600, 32'h3001_8002);
    check("R1 size 10 is short", 64'({mem_vld, res_vld}), 64'b11);
    // R9 same slot, mode differs by thread
    drive(2'd1, 32'h700, 32'h3002_1001);
    check("R9 single thread", 64'({mem_vld, res_vld, next_pc}), {2'b10, 32'h702});
    drive(2'd2, 32'h700, 32'h3002_1001);
    check("R9 dual thread", 64'({mem_vld, res_vld, next_pc}), {2'b11, 32'h704});
    // R7 single-mode upper arithmetic to memory lane
    drive(2'd1, 32'h702, 32'h0004_3002);
    check("R7 upper arith", 64'({mem_vld, mem_ins}), {1'b1, 32'h0004});
    // R11 idle cycle
    @(negedge clk);
    check("R11 idle", 64'({out_vld, mem_vld, res_vld, exc}), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule